// File: doc/BRIEF.md
# Synchronous Memory-Card Bus Monitor

This block watches a three-wire synchronous memory-card bus (reset, clock and a bidirectional data line) without ever driving it. All three lines are sampled by the faster system clock through synchronizers, and edges are found by comparing each new sample with the one before it. From these edges the monitor recovers bus reset events, command start and stop framing, and serial bytes.

Each byte is labelled with the phase of the bus at the moment it completes. A bus reset makes the following bytes answer-to-reset data. A command start makes them command bytes. A command stop makes them card response data. A bus reset is reported on its own one-cycle pulse. Each finished byte is reported as a one-cycle strobe together with its value and a 2-bit tag. The tag output always shows the current phase, so a start or a stop can be seen at the ports even before any byte follows it.

Top module: `card_bus_monitor`

## Requirements
- R1: While the active-high system reset `rst` is asserted, both strobes are low and the phase tag reads 0 (answer-to-reset).
- R2: A rising edge on `bus_rst` gives exactly one cycle of `rst_evt_o`. It discards any partly received byte and sets the phase tag to 0 (answer-to-reset).
- R3: A data bit is taken from `bus_io` on each rising edge of `bus_clk`, but only while `bus_rst` is low. Clock edges while `bus_rst` is high capture nothing.
- R4: Bits arrive least-significant first. The eighth captured bit raises `byte_valid_o` for one cycle, with the assembled value on `byte_o` and the phase tag on `byte_kind_o` (0 answer-to-reset, 1 command, 2 card data; 3 never appears).
- R5: A falling edge of `bus_io` while `bus_clk` is high is a command start. It sets the phase tag to 1 and discards any partial byte.
- R6: A rising edge of `bus_io` while `bus_clk` is high is a command stop. It sets the phase tag to 2 and discards any partial byte.
- R7: When conditions coincide in one sample, the bus reset edge wins over a clock edge, and a capturing clock edge wins over a start or stop. A losing condition has no effect, and a reset pulse and a byte strobe never appear together.
- R8: After a byte completes, bit count and accumulator restart from zero. Further bytes in the same phase carry the same tag and are reported on separate strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Active-high synchronous system reset |
| bus_rst | input | 1 | Card-bus reset line (asynchronous) |
| bus_clk | input | 1 | Card-bus clock line (asynchronous) |
| bus_io | input | 1 | Card-bus data line (asynchronous) |
| rst_evt_o | output | 1 | One-cycle pulse on a bus reset event |
| byte_valid_o | output | 1 | One-cycle strobe for a completed byte |
| byte_o | output | 8 | Value of the completed byte |
| byte_kind_o | output | 2 | Current phase tag: 0 ATR, 1 command, 2 data |

## Verification
The assertions assume that each bus line holds each level for at least two system clocks. Under that assumption a clock rising edge cannot repeat on the next sample, and a reset pulse cannot follow another reset pulse at once. The stimulus keeps every bus level for four system clocks. It changes the data line only while the bus clock is low, except where a start, a stop or a deliberate coincidence is being exercised. Coincident edges for the priority cases are always driven in a single step.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

    typedef enum logic [1:0] {
        KIND_ATR  = 2'd0,
        KIND_CMD  = 2'd1,
        KIND_DATA = 2'd2
    } kind_e;

    typedef struct packed {
        logic rst;
        logic clk;
        logic io;
    } bus_t;

endpackage

// File: rtl/cbm_sync.sv
module cbm_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cbm_edges.sv
module cbm_edges #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] cur_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= cur_i;
    end

    assign rise_o = cur_i & ~prev_q;
    assign fall_o = ~cur_i & prev_q;
endmodule

// File: rtl/cbm_core.sv
module cbm_core
    import cbm_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_t              level_i,
    input  bus_t              rise_i,
    input  bus_t              fall_i,
    output logic              evt_o,
    output logic              valid_o,
    output logic [BYTE_W-1:0] byte_o,
    output kind_e             kind_o
);
    localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        kind_e             kind;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] acc;
        logic [BYTE_W-1:0] out;
        logic              valid;
        logic              evt;
    } state_t;

    state_t st_d, st_q;
    logic [BYTE_W-1:0] shifted;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.evt   = 1'b0;
        shifted    = {level_i.io, st_q.acc[BYTE_W-1:1]};

        if (rise_i.rst) begin
            st_d.evt  = 1'b1;
            st_d.kind = KIND_ATR;
            st_d.cnt  = '0;
            st_d.acc  = '0;
        end else if (rise_i.clk && !level_i.rst) begin
            if (st_q.cnt == LAST_BIT) begin
                st_d.out   = shifted;
                st_d.valid = 1'b1;
                st_d.cnt   = '0;
                st_d.acc   = '0;
            end else begin
                st_d.acc = shifted;
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (level_i.clk && fall_i.io) begin
            st_d.kind = KIND_CMD;
            st_d.cnt  = '0;
            st_d.acc  = '0;
        end else if (level_i.clk && rise_i.io) begin
            st_d.kind = KIND_DATA;
            st_d.cnt  = '0;
            st_d.acc  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{kind: KIND_ATR, cnt: '0, acc: '0, out: '0,
                      valid: 1'b0, evt: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o   = st_q.evt;
    assign valid_o = st_q.valid;
    assign byte_o  = st_q.out;
    assign kind_o  = st_q.kind;
endmodule

// File: rtl/card_bus_monitor.sv
module card_bus_monitor
    import cbm_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rst,
    input  logic              bus_clk,
    input  logic              bus_io,
    output logic              rst_evt_o,
    output logic              byte_valid_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic [1:0]        byte_kind_o
);
    localparam int LINES = $bits(bus_t);

    bus_t  raw, level, rise, fall;
    kind_e kind;

    assign raw = '{rst: bus_rst, clk: bus_clk, io: bus_io};

    cbm_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_i(raw), .sync_o(level)
    );

    cbm_edges #(.WIDTH(LINES)) u_edges (
        .clk(clk), .rst(rst), .cur_i(level), .rise_o(rise), .fall_o(fall)
    );

    cbm_core #(.BYTE_W(BYTE_W)) u_core (
        .clk(clk), .rst(rst),
        .level_i(level), .rise_i(rise), .fall_i(fall),
        .evt_o(rst_evt_o), .valid_o(byte_valid_o),
        .byte_o(byte_o), .kind_o(kind)
    );

    assign byte_kind_o = kind;
endmodule

// File: rtl/card_bus_monitor_chk.sv
module card_bus_monitor_chk (
    input logic       clk,
    input logic       rst,
    input logic       rst_evt_o,
    input logic       byte_valid_o,
    input logic [1:0] byte_kind_o
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!rst_evt_o && !byte_valid_o && byte_kind_o == 2'd0));

    assert_evt_single_R2: assert property (@(posedge clk) disable iff (rst)
        rst_evt_o |=> !rst_evt_o);

    assert_evt_sets_atr_R2: assert property (@(posedge clk) disable iff (rst)
        rst_evt_o |-> byte_kind_o == 2'd0);

    assert_kind_legal_R4: assert property (@(posedge clk) disable iff (rst)
        byte_kind_o != 2'd3);

    assert_no_coincide_R7: assert property (@(posedge clk) disable iff (rst)
        !(rst_evt_o && byte_valid_o));

    assert_valid_single_R8: assert property (@(posedge clk) disable iff (rst)
        byte_valid_o |=> !byte_valid_o);

    assert_kind_held_R8: assert property (@(posedge clk) disable iff (rst)
        byte_valid_o |-> $stable(byte_kind_o));
endmodule

bind card_bus_monitor card_bus_monitor_chk u_chk (
    .clk(clk), .rst(rst), .rst_evt_o(rst_evt_o),
    .byte_valid_o(byte_valid_o), .byte_kind_o(byte_kind_o)
);

// File: tb/card_bus_monitor_tb_top.sv
module card_bus_monitor_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  HOLD       = 4;

    typedef struct {
        bit       is_evt;
        bit [7:0] val;
        bit [1:0] kind;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_rst = 1'b0, bus_clk = 1'b0, bus_io = 1'b1;
    logic       rst_evt_o, byte_valid_o;
    logic [7:0] byte_o;
    logic [1:0] byte_kind_o;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    item_t exp_q[$];

    card_bus_monitor dut_i (
        .clk(clk), .rst(rst), .bus_rst(bus_rst), .bus_clk(bus_clk),
        .bus_io(bus_io), .rst_evt_o(rst_evt_o), .byte_valid_o(byte_valid_o),
        .byte_o(byte_o), .byte_kind_o(byte_kind_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        bus_io = b;  hold();
        bus_clk = 1'b1; hold();
        bus_clk = 1'b0; hold();
    endtask

    task automatic send_byte(input logic [7:0] v, input logic [1:0] k);
        exp_q.push_back('{is_evt: 1'b0, val: v, kind: k});
        for (int i = 0; i < 8; i++) bit_out(v[i]);
    endtask

    task automatic bus_reset();
        exp_q.push_back('{is_evt: 1'b1, val: 8'h00, kind: 2'd0});
        bus_rst = 1'b1; hold();
    endtask

    task automatic start_cond();
        bus_io = 1'b1; hold();
        bus_clk = 1'b1; hold();
        bus_io = 1'b0; hold();
        bus_clk = 1'b0; hold();
    endtask

    task automatic stop_cond();
        bus_io = 1'b0; hold();
        bus_clk = 1'b1; hold();
        bus_io = 1'b1; hold();
        bus_clk = 1'b0; hold();
    endtask

    // Monitor: pops the scoreboard whenever the design reports something
    always @(negedge clk) begin
        if (!rst && (rst_evt_o || byte_valid_o)) begin
            if (exp_q.size() == 0) begin
                check("R4 unexpected output", 1, 0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check("R7 reset and byte together", int'(rst_evt_o && byte_valid_o), 0);
                if (e.is_evt) begin
                    check("R2 reset event pulse", int'(rst_evt_o), 1);
                end else begin
                    check("R4 byte strobe", int'(byte_valid_o), 1);
                    check("R4 byte value", int'(byte_o), int'(e.val));
                    check("R4 byte tag", int'(byte_kind_o), int'(e.kind));
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 evt in reset", int'(rst_evt_o), 0);
        check("R1 valid in reset", int'(byte_valid_o), 0);
        check("R1 tag in reset", int'(byte_kind_o), 0);
        rst = 1'b0;
        hold();

        // R2 / R3: bus reset, clock pulses ignored while reset high
        bus_reset();
        for (int i = 0; i < 3; i++) begin
            bus_clk = 1'b1; hold();
            bus_clk = 1'b0; hold();
        end
        check("R2 tag after bus reset", int'(byte_kind_o), 0);
        bus_rst = 1'b0; hold();
        send_byte(8'h3B, 2'd0);

        // R2 / R7: partial byte, then reset edge together with clock edge
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        bus_io = 1'b1;
        exp_q.push_back('{is_evt: 1'b1, val: 8'h00, kind: 2'd0});
        bus_rst = 1'b1; bus_clk = 1'b1; hold();
        bus_clk = 1'b0; hold();
        bus_rst = 1'b0; hold();
        send_byte(8'hC6, 2'd0);

        // R5: start condition, partial then fresh command bytes
        start_cond();
        check("R5 tag after start", int'(byte_kind_o), 1);
        bit_out(1'b1); bit_out(1'b1);
        start_cond();
        check("R5 tag after second start", int'(byte_kind_o), 1);
        send_byte(8'h30, 2'd1);
        send_byte(8'hA5, 2'd1);   // R8 same phase, second byte

        // R6: stop condition, response data
        stop_cond();
        check("R6 tag after stop", int'(byte_kind_o), 2);
        send_byte(8'hFF, 2'd2);
        send_byte(8'h00, 2'd2);   // R8

        // R7: clock rise and data fall in the same sample: bit wins, no start
        bus_io = 1'b1; hold();
        exp_q.push_back('{is_evt: 1'b0, val: 8'h5A, kind: 2'd2});
        bus_clk = 1'b1; bus_io = 1'b0; hold();
        bus_clk = 1'b0; hold();
        check("R7 tag kept on coincident edge", int'(byte_kind_o), 2);
        for (int i = 1; i < 8; i++) bit_out(logic'((8'h5A >> i) & 1));
        check("R7 tag after byte", int'(byte_kind_o), 2);

        hold(); hold();
        check("R8 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule